// File: doc/BRIEF.md
# Message-Sequenced SPI Master

This block is an SPI master that runs a whole message from a single command, so software does not have to pace each byte. Software first places up to one buffer's worth of bytes in the transmit buffer. It then writes a message-control word that gives the byte count and the transfer type, and finally writes a command word that names the target device and starts the message. The block drives SCLK, MOSI and one active-low chip select, and places the bytes it receives in a receive buffer. When the message ends, it reports how many received bytes are valid and sets a command-done status bit, which can raise an interrupt.

All registers sit on one 16-bit write/read port with a combinational read. For a buffer depth D (default 64), addresses below D are the buffer window: a write goes to the transmit buffer and a read comes from the receive buffer. The control registers follow the window: D+0 is the configuration register, D+1 the message-control word, D+2 the command word, D+3 the interrupt status, D+4 the interrupt mask, D+5 the busy flag and D+6 the receive tail. A transfer longer than the buffer is split by software across several commands.

Top module: `msg_spi_master`

## Requirements
- R1: After reset, every cs_n line is high, sclk, mosi and irq are low, and the busy, status, mask and receive-tail registers all read 0.
- R2: A command write (D+2) starts a message only when bits [3:0] equal 1 and the device number in bits [15:12] is below NUM_CS. Bits [7:4] hold the prepend count. Any other command write starts nothing.
- R3: The message-control word (D+1, CTL_W bits) holds the byte count below bit TYPE_POS. A count above D is treated as D. A count of 0 completes the message with no SCLK edge.
- R4: The 2-bit type field sits at TYPE_POS: 0 = full duplex, 1 = half-duplex read, 2 = half-duplex write, and 3 behaves as 0. In full duplex, byte i of the transmit buffer is shifted out MSB first, received byte i lands at receive index i, and the tail equals the count.
- R5: In a half-duplex read, MOSI is low for every byte after the prepend bytes. Those bytes are stored from receive index 0, and the tail equals the count minus the prepend bytes.
- R6: In a half-duplex write, MISO is never stored. The tail reads 0 and the receive buffer keeps its contents.
- R7: For every type, the first min(prepend, count) bytes are shifted out from the transmit buffer and are not stored.
- R8: Configuration bit 3 sets the SCLK idle level (it is followed while idle). Bit 4 selects the capture edge: the leading edge when 0 and the trailing edge when 1, with MOSI changing on the other edge.
- R9: Configuration bits [2:0] = k set the SCLK half period to BASE_HALF·2^k clock cycles. The value 7 behaves as 6.
- R10: From command acceptance until completion, exactly the selected cs_n line is low, and it stays low across every SCLK edge of the message.
- R11: The busy flag (D+5, bit 0) reads 1 while a message runs. A command written while busy is ignored.
- R12: At the end of a message, status bit 0 (D+3) is set. Writing 1 to bit 0 clears it, but a completion in the same cycle as the clear leaves it set.
- R13: irq equals status bit 0 ANDed with mask bit 0 (D+4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | log2(DEPTH)+1 | Register / buffer address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data |
| irq | output | 1 | Masked command-done interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NUM_CS | Active-low chip selects |

## Verification
Two events can fall in the same clock edge: the end of a message setting the command-done bit, and a software write-1-to-clear of that bit. The bench provokes the collision with a zero-count message at the fastest rate, so completion follows exactly one cycle after the command, and it drives the clear write in that same cycle. The status must read back as 1. A second collision, a command written while a message runs, is judged by the chip-select lines touched and the number of bits shifted.

// File: rtl/msg_spi_master.sv
module msg_spi_master #(
  parameter int DEPTH     = 64,
  parameter int NUM_CS    = 4,
  parameter int CTL_W     = 16,
  parameter int TYPE_POS  = 14,
  parameter int BASE_HALF = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [$clog2(DEPTH):0]   reg_addr,
  input  logic [15:0]              reg_wdata,
  output logic [15:0]              reg_rdata,
  output logic                     irq,
  output logic                     sclk,
  output logic                     mosi,
  input  logic                     miso,
  output logic [NUM_CS-1:0]        cs_n
);
  localparam int AW  = $clog2(DEPTH) + 1;
  localparam int IW  = $clog2(DEPTH);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int IDW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam int TW  = $clog2(BASE_HALF * 64) + 1;
  localparam logic [AW-1:0] A_CFG  = AW'(DEPTH);
  localparam logic [AW-1:0] A_MSG  = AW'(DEPTH + 1);
  localparam logic [AW-1:0] A_CMD  = AW'(DEPTH + 2);
  localparam logic [AW-1:0] A_IST  = AW'(DEPTH + 3);
  localparam logic [AW-1:0] A_IMK  = AW'(DEPTH + 4);
  localparam logic [AW-1:0] A_BSY  = AW'(DEPTH + 5);
  localparam logic [AW-1:0] A_TAIL = AW'(DEPTH + 6);
  localparam logic [1:0] T_HDR = 2'd1;
  localparam logic [1:0] T_HDW = 2'd2;
  localparam logic [3:0] OP_GO = 4'h1;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_HOLD} st_t;

  logic [7:0] tx_mem [DEPTH];
  logic [7:0] rx_mem [DEPTH];
  st_t st;
  logic [4:0] cfg;
  logic [CTL_W-1:0] msg_q;
  logic [TW-1:0] tmr, half_q, half_v;
  logic [1:0] typ_q;
  logic [3:0] pre_q, edg;
  logic [CW-1:0] cnt_q, idx, tail, cnt_eff, ld_idx;
  logic [7:0] sr, rxsr, ld_byte;
  logic cpha_q, mosi_q, sclk_q, done_st, mask;
  logic [IDW-1:0] sel;
  logic [TYPE_POS-1:0] cnt_raw;
  logic [2:0] rate_eff;
  logic [1:0] ld_typ;
  logic [3:0] ld_pre;

  wire busy   = st != S_IDLE;
  wire cmd_we = reg_we && reg_addr == A_CMD;
  wire go     = cmd_we && !busy && reg_wdata[3:0] == OP_GO && int'(reg_wdata[15:12]) < NUM_CS;
  wire tick   = tmr == '0;
  wire [1:0] new_typ = msg_q[TYPE_POS+1:TYPE_POS];
  wire cap_en = typ_q != T_HDW && int'(idx) >= int'(pre_q);
  wire [7:0] cap_byte = cpha_q ? {rxsr[6:0], miso} : rxsr;
  wire byte_end = st == S_SHIFT && tick && edg == 4'd15;
  wire last = (idx + 1'b1) == cnt_q;

  assign cnt_raw  = msg_q[TYPE_POS-1:0];
  assign cnt_eff  = (int'(cnt_raw) > DEPTH) ? CW'(DEPTH) : CW'(cnt_raw);
  assign rate_eff = (cfg[2:0] == 3'd7) ? 3'd6 : cfg[2:0];
  assign half_v   = TW'(BASE_HALF) << rate_eff;
  assign ld_idx   = busy ? idx + 1'b1 : '0;
  assign ld_typ   = busy ? typ_q : new_typ;
  assign ld_pre   = busy ? pre_q : reg_wdata[7:4];
  assign ld_byte  = (int'(ld_idx) < int'(ld_pre) || ld_typ != T_HDR) ? tx_mem[ld_idx[IW-1:0]] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cfg <= '0; msg_q <= '0; tmr <= '0; half_q <= '0;
      typ_q <= '0; pre_q <= '0; edg <= '0; cnt_q <= '0; idx <= '0; tail <= '0;
      sr <= '0; rxsr <= '0; cpha_q <= 1'b0; mosi_q <= 1'b0; sclk_q <= 1'b0;
      done_st <= 1'b0; mask <= 1'b0; sel <= '0;
    end else begin
      if (reg_we && reg_addr == A_CFG) cfg <= reg_wdata[4:0];
      if (reg_we && reg_addr == A_MSG) msg_q <= reg_wdata[CTL_W-1:0];
      if (reg_we && reg_addr == A_IMK) mask <= reg_wdata[0];
      if (reg_we && reg_addr == A_IST && reg_wdata[0]) done_st <= 1'b0;
      case (st)
        S_IDLE: begin
          sclk_q <= cfg[3];
          if (go) begin
            sel <= IDW'(reg_wdata[15:12]);
            typ_q <= new_typ; pre_q <= reg_wdata[7:4]; cnt_q <= cnt_eff;
            idx <= '0; edg <= '0; tail <= '0; cpha_q <= cfg[4];
            half_q <= half_v; tmr <= half_v - 1'b1;
            if (cnt_eff == '0) st <= S_HOLD;
            else begin
              st <= S_SHIFT;
              if (cfg[4]) sr <= ld_byte;
              else begin mosi_q <= ld_byte[7]; sr <= {ld_byte[6:0], 1'b0}; end
            end
          end
        end
        S_SHIFT: begin
          if (tick) begin
            sclk_q <= ~sclk_q;
            edg <= edg + 1'b1;
            tmr <= half_q - 1'b1;
            if (!edg[0] != cpha_q) rxsr <= {rxsr[6:0], miso};
            else begin mosi_q <= sr[7]; sr <= {sr[6:0], 1'b0}; end
            if (edg == 4'd15) begin
              if (cap_en) tail <= tail + 1'b1;
              if (last) st <= S_HOLD;
              else begin
                idx <= idx + 1'b1;
                if (cpha_q) sr <= ld_byte;
                else begin mosi_q <= ld_byte[7]; sr <= {ld_byte[6:0], 1'b0}; end
              end
            end
          end else tmr <= tmr - 1'b1;
        end
        S_HOLD: begin
          if (tick) begin st <= S_IDLE; done_st <= 1'b1; mosi_q <= 1'b0; end
          else tmr <= tmr - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (reg_we && reg_addr < A_CFG) tx_mem[reg_addr[IW-1:0]] <= reg_wdata[7:0];
    if (byte_end && cap_en) rx_mem[tail[IW-1:0]] <= cap_byte;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr < A_CFG) reg_rdata[7:0] = rx_mem[reg_addr[IW-1:0]];
    else if (reg_addr == A_CFG) reg_rdata[4:0] = cfg;
    else if (reg_addr == A_MSG) reg_rdata[CTL_W-1:0] = msg_q;
    else if (reg_addr == A_IST) reg_rdata[0] = done_st;
    else if (reg_addr == A_IMK) reg_rdata[0] = mask;
    else if (reg_addr == A_BSY) reg_rdata[0] = busy;
    else if (reg_addr == A_TAIL) reg_rdata[CW-1:0] = tail;
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = !(busy && sel == IDW'(g));
  end

  assign irq  = done_st & mask;
  assign sclk = sclk_q;
  assign mosi = mosi_q;

  // R10
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n));
  // R10
  cs_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$stable(sclk)) |-> $countones(~cs_n) == 1);
  // R12
  done_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done_st);
  // R11
  cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_we) |=> ($stable(sel) && $stable(cnt_q)));
  // R6
  hdw_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && typ_q == T_HDW) |-> tail == '0);
  // R3
  tail_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) tail <= cnt_q);
endmodule

// File: tb/tb_msg_spi_master.sv
module tb_msg_spi_master;
  localparam int CFG = 64, MSG = 65, CMD = 66, IST = 67, IMK = 68, BSY = 69, TAIL = 70;

  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [6:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  wire [15:0] reg_rdata;
  wire irq, sclk, mosi;
  logic miso;
  wire [3:0] cs_n;

  always #5 clk = ~clk;

  msg_spi_master dut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n));

  int errors = 0, checks = 0, cyc = 0;
  int n = 0, rseed = 0, ecount = 0, e_first = 0, e_second = 0;
  logic bm_cpol = 0, bm_cpha = 0;
  logic [3:0] cs_seen = '0;
  logic [7:0] mcap [0:63];
  logic [7:0] shadow [0:63];

  function automatic logic [7:0] rep(input int j);
    return 8'(j * 29 + 91) ^ 8'hC3;
  endfunction
  function automatic logic [7:0] txb(input int i, input int s);
    return 8'(i * 7 + s * 13 + 1);
  endfunction

  always_comb miso = rep(n / 8 + rseed) >> (7 - n % 8);

  always @(negedge clk) begin cyc++; cs_seen |= ~cs_n; end

  always @(sclk) if (cs_n != 4'hF) begin
    if (ecount == 0) e_first = cyc; else if (ecount == 1) e_second = cyc;
    ecount++;
  end

  task automatic samp();
    if (n < 512) mcap[n / 8] = {mcap[n / 8][6:0], mosi};
    n++;
  endtask
  always @(posedge sclk) if (bm_cpol == bm_cpha && cs_n != 4'hF) samp();
  always @(negedge sclk) if (bm_cpol != bm_cpha && cs_n != 4'hF) samp();

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_we = 1; reg_addr = 7'(a); reg_wdata = 16'(d);
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); reg_addr = 7'(a); #1 d = int'(reg_rdata);
  endtask

  task automatic wait_idle();
    int b = 1;
    for (int k = 0; k < 100000 && b != 0; k++) rd(BSY, b);
  endtask

  task automatic run_msg(input int mode, input int typ, input int pre, input int cnt,
                         input int rate, input int id, input int seed);
    int ce, v, expt, pe;
    ce = cnt > 64 ? 64 : cnt;
    pe = pre < ce ? pre : ce;
    for (int i = 0; i < ce; i++) wr(i, int'(txb(i, seed)));
    bm_cpol = mode[1]; bm_cpha = mode[0];
    wr(CFG, rate | (mode[1] << 3) | (mode[0] << 4));
    wr(MSG, (typ << 14) | cnt);
    n = 0; ecount = 0; cs_seen = '0; rseed = seed;
    wr(CMD, (id << 12) | (pre << 4) | 1);
    wait_idle();
    chk("R8 bits shifted", n, 8 * ce);
    chk("R10 chip select", int'(cs_seen), 1 << id);
    expt = (typ == 2) ? 0 : ce - pe;
    rd(TAIL, v); chk(typ == 2 ? "R6 tail" : "R5 tail", v, expt);
    for (int i = 0; i < ce; i++)
      chk((i < pe) ? "R7 prepend mosi" : (typ == 1 ? "R5 mosi low" : "R4 mosi"),
          int'(mcap[i]), (i < pe || typ != 1) ? int'(txb(i, seed)) : 0);
    if (typ != 2) for (int i = pe; i < ce; i++) shadow[i - pe] = rep(i + seed);
    for (int j = 0; j < ce; j++) begin
      rd(j, v); chk(typ == 2 ? "R6 rx kept" : "R4 rx data", v, int'(shadow[j]));
    end
  endtask

  initial begin
    #1900000;
    errors++; checks++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    chk("R1 cs_n", int'(cs_n), 15);
    chk("R1 sclk", int'(sclk), 0);
    chk("R1 mosi", int'(mosi), 0);
    chk("R1 irq", int'(irq), 0);
    rst_n = 1;
    rd(BSY, v); chk("R1 busy", v, 0);
    rd(IST, v); chk("R1 status", v, 0);
    rd(IMK, v); chk("R1 mask", v, 0);
    rd(TAIL, v); chk("R1 tail", v, 0);

    // R3 count above depth is capped
    run_msg(0, 0, 0, 100, 0, 0, 3);

    // R4 R5 R6 R7 R8 sweep over modes, types, prepend and counts
    for (int m = 0; m < 4; m++)
      for (int p = 0; p <= 2; p += 2)
        for (int c = 1; c <= 5; c += 2)
          for (int t = 0; t < 4; t++)
            run_msg(m, t, p, c, 0, (m + t) % 4, m * 11 + t * 5 + c + p);

    // R9 rate sweep
    for (int k = 0; k < 8; k++) begin
      run_msg(k % 4, 0, 0, 1, k, k % 4, 40 + k);
      chk("R9 half period", e_second - e_first, 1 << ((k == 7) ? 6 : k));
      chk("R9 edge count", ecount, 16);
    end

    // R8 idle level follows polarity
    wr(CFG, 8); @(negedge clk); chk("R8 idle high", int'(sclk), 1);
    wr(CFG, 0); @(negedge clk); chk("R8 idle low", int'(sclk), 0);

    // R12 completion and clear in the same cycle; R3 zero count
    wr(IST, 1); wr(MSG, 0); n = 0; ecount = 0;
    @(negedge clk); reg_we = 1; reg_addr = 7'(CMD); reg_wdata = 16'h0001;
    @(negedge clk); reg_addr = 7'(IST); reg_wdata = 16'h0001;
    @(negedge clk); reg_we = 0;
    rd(IST, v); chk("R12 set wins", v, 1);
    chk("R3 zero count edges", ecount, 0);

    // R13 interrupt masking, R12 clear
    @(negedge clk); chk("R13 masked", int'(irq), 0);
    wr(IMK, 1); chk("R13 unmasked", int'(irq), 1);
    wr(IST, 1); chk("R13 after clear", int'(irq), 0);
    rd(IST, v); chk("R12 cleared", v, 0);

    // R11 command while busy is ignored
    wr(CFG, 2); wr(MSG, 4); n = 0; cs_seen = '0; bm_cpol = 0; bm_cpha = 0;
    wr(CMD, (1 << 12) | 1);
    rd(BSY, v); chk("R11 busy", v, 1);
    wr(CMD, (2 << 12) | 1);
    wait_idle();
    chk("R11 single device", int'(cs_seen), 2);
    chk("R11 bits", n, 32);
    repeat (3) @(negedge clk);
    rd(BSY, v); chk("R11 no restart", v, 0);

    // R2 invalid device and wrong opcode start nothing
    wr(IST, 1); cs_seen = '0;
    wr(CMD, (4 << 12) | 1);
    rd(BSY, v); chk("R2 bad device", v, 0);
    wr(CMD, (1 << 12) | 2);
    rd(BSY, v); chk("R2 bad opcode", v, 0);
    rd(IST, v); chk("R2 no done", v, 0);
    chk("R2 no select", int'(cs_seen), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule